// File: doc/BRIEF.md
# Program Memory Table Read Unit

This unit carries out table-lookup reads from a 16-bit-wide program memory for a small microcontroller core. Software loads a low and a high table pointer through the core's register file. It then issues one of two read operations. The unit fetches the addressed program word and splits it in two. The low byte is written to a data-memory location named by the operation. The high byte is loaded into a dedicated latch that software can read but cannot write.

The operation is selected by `op_last`. With `op_last = 0` (paged mode), the upper word-address bits come from the high pointer. With `op_last = 1` (last-page mode), the high pointer is ignored and the upper bits are forced to all ones, which selects the final page of program memory. In both modes the low pointer supplies the low eight address bits.

The control is a three-state machine:
- `ST_IDLE` is the rest state.
- `ST_FETCH` is cycle 1. The table address is driven onto `pm_addr` and `busy` is high, so the core stalls its own fetch.
- `ST_WRITE` is cycle 2. The synchronously read word is returned, the low byte is written to data memory, and the high-byte latch is loaded at the closing edge.

The transitions are:
- `accept`: `ST_IDLE` or `ST_WRITE` to `ST_FETCH`, taken when `op_valid` is high.
- `fetch_done`: `ST_FETCH` to `ST_WRITE`, taken unconditionally.
- `retire`: `ST_WRITE` to `ST_IDLE`, taken when `op_valid` is low.

`op_valid` is not sampled in `ST_FETCH`.

Top module: `tblrd_unit`

## Requirements
- R1: After reset, both pointers and the high-byte latch read as 0x00, and `busy` and `dm_we` are low.
- R2: A register-port write with `reg_we` high to address 0x05 loads the low pointer, and one to address 0x06 loads the high pointer. `reg_rdata` returns the addressed register combinationally, and all 8 bits of each pointer read back as written.
- R3: During cycle 1 of either operation, `pm_addr[7:0]` equals the low pointer.
- R4: In paged mode (`op_last = 0`), `pm_addr[12:8]` equals bits 4..0 of the high pointer. Bits 7..5 of the high pointer do not affect the address.
- R5: In last-page mode (`op_last = 1`), `pm_addr[12:8]` is 5'b11111 whatever the high pointer holds.
- R6: In cycle 2, `dm_we` is high for exactly one cycle, with `dm_waddr` equal to the `op_dest` captured at acceptance and `dm_wdata` equal to bits 7..0 of the fetched word.
- R7: From the cycle after cycle 2, register address 0x07 reads bits 15..8 of the fetched word. A later operation overwrites the previous value.
- R8: A register-port write to address 0x07 has no effect on the latch.
- R9: `busy` is high exactly in the cycle after an operation is accepted, and every operation spans two cycles. A new operation may be accepted in cycle 2 of the previous one, so reads can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Start a table read (not sampled during cycle 1) |
| op_last | input | 1 | 0: paged by the high pointer; 1: last page |
| op_dest | input | 8 | Data-memory address for the low byte |
| busy | output | 1 | High in cycle 1; the core stalls |
| pm_addr | output | 13 | Program-memory word address |
| pm_rdata | input | 16 | Program word, registered one cycle after `pm_addr` |
| dm_we | output | 1 | Data-memory write strobe |
| dm_waddr | output | 8 | Data-memory write address |
| dm_wdata | output | 8 | Low byte of the fetched word |
| reg_we | input | 1 | Register-file write strobe |
| reg_addr | input | 8 | Register-file address |
| reg_wdata | input | 8 | Register-file write data |
| reg_rdata | output | 8 | Register-file read data, combinational |

## Verification
The bench targets the following corner cases:
- **High pointer with bits 7..5 set.** A design that used the whole high pointer, or the wrong slice of it, would put a wrong page on `pm_addr`.
- **Last-page mode with a non-trivial high pointer.** A design that failed to force the page would follow the high pointer instead of selecting the final page.
- **Latch write attempt.** A register write aimed at the latch must leave it unchanged, and a later read must overwrite it. A design that treated the latch as writable would show the value software wrote.
- **Back-to-back reads.** These check that a second acceptance in cycle 2 neither loses the first write nor shifts its latch update by a cycle. A design that stretched `busy` would miss the second write.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WRITE = 2'd2
    } tr_state_e;

    typedef enum logic {
        MODE_PAGED = 1'b0,
        MODE_LAST  = 1'b1
    } tr_mode_e;
endpackage

// File: rtl/tblrd_addr_gen.sv
module tblrd_addr_gen
    import tblrd_pkg::*;
#(
    parameter int PM_AW  = 13,
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] lo_ptr,
    input  logic [BYTE_W-1:0] hi_ptr,
    input  tr_mode_e          mode,
    output logic [PM_AW-1:0]  addr
);
    localparam int PG_W = PM_AW - BYTE_W;

    logic [PG_W-1:0] page;

    always_comb begin
        unique case (mode)
            MODE_LAST:  page = '1;
            default:    page = hi_ptr[PG_W-1:0];
        endcase
    end

    assign addr = {page, lo_ptr};
endmodule

// File: rtl/tblrd_regs.sv
module tblrd_regs #(
    parameter int            BYTE_W     = 8,
    parameter int            RF_AW      = 8,
    parameter logic [RF_AW-1:0] LO_ADR  = 8'h05,
    parameter logic [RF_AW-1:0] HI_ADR  = 8'h06,
    parameter logic [RF_AW-1:0] LAT_ADR = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RF_AW-1:0]  reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              lat_ld,
    input  logic [BYTE_W-1:0] lat_din,
    output logic [BYTE_W-1:0] lo_ptr,
    output logic [BYTE_W-1:0] hi_ptr
);
    logic [BYTE_W-1:0] hi_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_ptr <= '0;
            hi_ptr <= '0;
        end else if (reg_we) begin
            if (reg_addr == LO_ADR) lo_ptr <= reg_wdata;
            if (reg_addr == HI_ADR) hi_ptr <= reg_wdata;
        end
    end

    // latch is loaded only by the read engine; the register port cannot reach it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hi_lat <= '0;
        else if (lat_ld) hi_lat <= lat_din;
    end

    always_comb begin
        if (reg_addr == LO_ADR)       reg_rdata = lo_ptr;
        else if (reg_addr == HI_ADR)  reg_rdata = hi_ptr;
        else if (reg_addr == LAT_ADR) reg_rdata = hi_lat;
        else                          reg_rdata = '0;
    end

    // R8
    latch_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_ld |=> $stable(hi_lat));
endmodule

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl
    import tblrd_pkg::*;
#(
    parameter int DM_AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_last,
    input  logic [DM_AW-1:0] op_dest,
    output tr_mode_e         mode,
    output logic [DM_AW-1:0] dest,
    output logic             busy,
    output logic             wr_phase
);
    tr_state_e state, state_nx;
    logic      accept;

    assign accept = op_valid && (state != ST_FETCH);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (op_valid) state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_WRITE;
            ST_WRITE: state_nx = op_valid ? ST_FETCH : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            mode  <= MODE_PAGED;
            dest  <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                mode <= tr_mode_e'(op_last);
                dest <= op_dest;
            end
        end
    end

    always_comb begin
        busy     = 1'b0;
        wr_phase = 1'b0;
        unique case (state)
            ST_FETCH: busy     = 1'b1;
            ST_WRITE: wr_phase = 1'b1;
            default:  ;
        endcase
    end

    // R9
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // R9
    accept_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |=> busy);
    // R6
    write_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> wr_phase);
    // R6
    write_has_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase |-> $past(busy));
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
    import tblrd_pkg::*;
#(
    parameter int                PM_WORDS = 8192,
    parameter int                WORD_W   = 16,
    parameter int                DM_AW    = 8,
    parameter int                RF_AW    = 8,
    parameter logic [RF_AW-1:0]  LO_ADR   = 8'h05,
    parameter logic [RF_AW-1:0]  HI_ADR   = 8'h06,
    parameter logic [RF_AW-1:0]  LAT_ADR  = 8'h07
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  logic                     op_last,
    input  logic [DM_AW-1:0]         op_dest,
    output logic                     busy,
    output logic [$clog2(PM_WORDS)-1:0] pm_addr,
    input  logic [WORD_W-1:0]        pm_rdata,
    output logic                     dm_we,
    output logic [DM_AW-1:0]         dm_waddr,
    output logic [WORD_W/2-1:0]      dm_wdata,
    input  logic                     reg_we,
    input  logic [RF_AW-1:0]         reg_addr,
    input  logic [WORD_W/2-1:0]      reg_wdata,
    output logic [WORD_W/2-1:0]      reg_rdata
);
    localparam int PM_AW  = $clog2(PM_WORDS);
    localparam int BYTE_W = WORD_W / 2;

    tr_mode_e          mode;
    logic [BYTE_W-1:0] lo_ptr, hi_ptr;
    logic              wr_phase;

    tblrd_ctrl #(.DM_AW(DM_AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_last  (op_last),
        .op_dest  (op_dest),
        .mode     (mode),
        .dest     (dm_waddr),
        .busy     (busy),
        .wr_phase (wr_phase)
    );

    tblrd_addr_gen #(.PM_AW(PM_AW), .BYTE_W(BYTE_W)) u_addr (
        .lo_ptr (lo_ptr),
        .hi_ptr (hi_ptr),
        .mode   (mode),
        .addr   (pm_addr)
    );

    tblrd_regs #(
        .BYTE_W (BYTE_W), .RF_AW (RF_AW),
        .LO_ADR (LO_ADR), .HI_ADR (HI_ADR), .LAT_ADR (LAT_ADR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lat_ld    (wr_phase),
        .lat_din   (pm_rdata[WORD_W-1:BYTE_W]),
        .lo_ptr    (lo_ptr),
        .hi_ptr    (hi_ptr)
    );

    assign dm_we    = wr_phase;
    assign dm_wdata = pm_rdata[BYTE_W-1:0];

    // R3
    low_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> pm_addr[BYTE_W-1:0] == lo_ptr);
    // R5
    last_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode == MODE_LAST) |-> &pm_addr[PM_AW-1:BYTE_W]);
    // R4
    paged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode == MODE_PAGED) |-> pm_addr[PM_AW-1:BYTE_W] == hi_ptr[PM_AW-BYTE_W-1:0]);
endmodule

// File: tb/tblrd_unit_bench.sv
`timescale 1ns/1ps
module tblrd_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_last = 1'b0;
    logic [7:0]  op_dest = '0;
    logic        busy;
    logic [12:0] pm_addr;
    logic [15:0] pm_rdata = '0;
    logic        dm_we;
    logic [7:0]  dm_waddr, dm_wdata;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0, reg_wdata = '0, reg_rdata;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] lo_s = '0, hi_s = '0;

    always #2.5 clk = ~clk;

    tblrd_unit u_tblrd_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_last(op_last),
        .op_dest(op_dest), .busy(busy), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
        .dm_we(dm_we), .dm_waddr(dm_waddr), .dm_wdata(dm_wdata),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [15:0] mem_fn(input logic [12:0] a);
        logic [31:0] p;
        p = {19'd0, a} * 32'h9E37 + 32'h1357;
        return p[15:0] ^ 16'h5AA5;
    endfunction

    always @(posedge clk) pm_rdata <= mem_fn(pm_addr);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 8'h05) lo_s = d;
        if (a == 8'h06) hi_s = d;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic logic [12:0] exp_addr(input logic last);
        return last ? {5'h1F, lo_s} : {hi_s[4:0], lo_s};
    endfunction

    task automatic run_op(input logic last, input logic [7:0] dest, input string req);
        logic [12:0] ea;
        logic [15:0] w;
        logic [7:0]  r;
        ea = exp_addr(last);
        w  = mem_fn(ea);
        @(negedge clk);
        op_valid = 1'b1; op_last = last; op_dest = dest;
        @(negedge clk);
        chk({req, " R9 busy in cycle 1"}, busy, 1);
        chk({req, " R3 low address"}, pm_addr[7:0], lo_s);
        chk({req, " page bits"}, pm_addr[12:8], ea[12:8]);
        op_valid = 1'b0;
        @(negedge clk);
        chk({req, " R9 busy gone in cycle 2"}, busy, 0);
        chk({req, " R6 dm_we"}, dm_we, 1);
        chk({req, " R6 dm_waddr"}, dm_waddr, dest);
        chk({req, " R6 dm_wdata"}, dm_wdata, w[7:0]);
        @(negedge clk);
        chk({req, " R6 dm_we single"}, dm_we, 0);
        rd_reg(8'h07, r);
        chk({req, " R7 latch"}, r, w[15:8]);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 dm_we", dm_we, 0);
        rd_reg(8'h05, r); chk("R1 lo ptr", r, 0);
        rd_reg(8'h06, r); chk("R1 hi ptr", r, 0);
        rd_reg(8'h07, r); chk("R1 latch", r, 0);
    endtask

    task automatic t_ptr_rw();
        logic [7:0] r;
        wr_reg(8'h05, 8'hA7);
        wr_reg(8'h06, 8'hE3);
        rd_reg(8'h05, r); chk("R2 lo readback", r, 8'hA7);
        rd_reg(8'h06, r); chk("R2 hi readback full width", r, 8'hE3);
    endtask

    task automatic t_paged();
        wr_reg(8'h05, 8'h3C); wr_reg(8'h06, 8'hE9);   // R4 bits 7..5 set, page 9
        run_op(1'b0, 8'h21, "R4 paged hi=E9");
        wr_reg(8'h05, 8'hFF); wr_reg(8'h06, 8'h00);
        run_op(1'b0, 8'h40, "R4 paged hi=00");
    endtask

    task automatic t_last();
        wr_reg(8'h05, 8'h12); wr_reg(8'h06, 8'h03);
        run_op(1'b1, 8'h7E, "R5 last page hi=03");
        wr_reg(8'h05, 8'h00);
        run_op(1'b1, 8'hFF, "R5 last page lo=00");
    endtask

    task automatic t_latch_ro();
        logic [7:0] r0, r1;
        rd_reg(8'h07, r0);
        wr_reg(8'h07, ~r0);
        rd_reg(8'h07, r1);
        chk("R8 latch write ignored", r1, r0);
        wr_reg(8'h05, 8'h99); wr_reg(8'h06, 8'h1F);
        run_op(1'b0, 8'h05, "R7 overwrite");
    endtask

    task automatic t_b2b();
        logic [12:0] a1, a2;
        logic [15:0] w1, w2;
        logic [7:0]  r;
        wr_reg(8'h05, 8'h5A); wr_reg(8'h06, 8'h0B);
        a1 = exp_addr(1'b0); a2 = exp_addr(1'b1);
        w1 = mem_fn(a1); w2 = mem_fn(a2);
        @(negedge clk);
        op_valid = 1'b1; op_last = 1'b0; op_dest = 8'h10;
        @(negedge clk);
        chk("R9 b2b busy op1", busy, 1);
        chk("R4 b2b addr op1", pm_addr, a1);
        op_valid = 1'b0;
        @(negedge clk);
        chk("R6 b2b write op1", dm_we, 1);
        chk("R6 b2b data op1", dm_wdata, w1[7:0]);
        op_valid = 1'b1; op_last = 1'b1; op_dest = 8'h11;
        @(negedge clk);
        chk("R9 b2b busy op2", busy, 1);
        chk("R5 b2b addr op2", pm_addr, a2);
        chk("R9 b2b no write in fetch", dm_we, 0);
        rd_reg(8'h07, r); chk("R7 b2b latch op1", r, w1[15:8]);
        op_valid = 1'b0;
        @(negedge clk);
        chk("R6 b2b write op2", dm_we, 1);
        chk("R6 b2b dest op2", dm_waddr, 8'h11);
        chk("R6 b2b data op2", dm_wdata, w2[7:0]);
        @(negedge clk);
        rd_reg(8'h07, r); chk("R7 b2b latch op2", r, w2[15:8]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ptr_rw();
        t_paged();
        t_last();
        t_latch_ro();
        t_b2b();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule